// File: doc/BRIEF.md
# Thread Yield Qualifier Gating Unit

This unit decides what happens to a hardware thread that asks to wait on external events. A request carries a 32-bit operand and names one of several thread contexts. A positive operand is a bit vector: each of its low 31 bits picks one external event line. If the selection is allowed and one of the picked lines is active, the thread goes on at once. If none is active, the thread stalls until one becomes active. If the selection includes a line that supervisor code has not permitted, the request traps.

A permission mask decides which event lines unprivileged code may wait on. Only privileged writes can change it. Event lines are asynchronous to the core, so they pass through a two-flop synchronizer before any decision uses them. Each context has its own wait state, so a stalled context does not hold up the others.

Top module: `yield_gate`

## Requirements
- R1: For a positive operand (bit 31 clear, bits 30:0 not all zero), operand bit i selects event line `evt_in[i]`, for every i from 0 to 30, including bit 30.
- R2: A permitted positive request with no selected synchronized line active sets that context's `ctx_blocked` bit on the next cycle, and gives neither a resume nor a trap pulse.
- R3: A permitted positive request with a selected synchronized line already active pulses `ctx_resume` on the next cycle and never sets `ctx_blocked`.
- R4: A blocked context clears `ctx_blocked` and pulses `ctx_resume` in the same cycle once any of its selected lines is active after synchronization. A line that rises at the input is seen on the third rising clock edge.
- R5: If any selected bit has a clear permission bit, `ctx_trap` pulses on the next cycle, whatever the event lines show, and the context never blocks. The permission check has priority over the event check.
- R6: An operand of zero or with bit 31 set pulses `ctx_resume` on the next cycle, with no trap and no block, whatever the mask holds.
- R7: A write with `cfg_priv` high loads `cfg_wdata` into `perm_mask` on the next cycle. Reset clears the mask, so every positive request traps until a privileged write.
- R8: A write with `cfg_priv` low leaves `perm_mask` unchanged and pulses `cfg_err` for one cycle on the next cycle.
- R9: Contexts are independent. A request to a context that is already blocked is ignored, and requests to other contexts are served while it waits.
- R10: After reset, `ctx_blocked`, `ctx_resume`, `ctx_trap`, `cfg_err` and `perm_mask` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 31 | Asynchronous external event lines |
| req_vld | input | 1 | Yield request valid |
| req_ctx | input | 2 | Context issuing the request |
| req_opnd | input | 32 | Yield operand |
| cfg_wr_en | input | 1 | Mask write strobe |
| cfg_priv | input | 1 | Writer is privileged |
| cfg_wdata | input | 31 | New mask value |
| perm_mask | output | 31 | Current permission mask |
| cfg_err | output | 1 | Pulse for a rejected unprivileged write |
| ctx_blocked | output | 4 | Per-context stalled flag |
| ctx_resume | output | 4 | Per-context proceed pulse |
| ctx_trap | output | 4 | Per-context illegal-qualifier pulse |

## Verification
The bench issues a request that selects a forbidden line while that line is active. A design that checks events before permission would let this request resume instead of trapping it. It raises a line on bit 30 and counts edges to the wake pulse. A missing or extra synchronizer stage would move the pulse by a cycle, and a selection that drops the top bit would never wake the thread. It also re-requests a blocked context, sends zero and negative operands under a narrow mask, and makes an unprivileged write. A design that restarted the wait, trapped a non-positive operand or let the write through would show up on the outputs, which are compared every cycle with a behavioural model.

// File: rtl/yield_gate_pkg.sv
package yield_gate_pkg;
  typedef enum logic [1:0] {
    DEC_NONE = 2'd0,
    DEC_GO   = 2'd1,
    DEC_TRAP = 2'd2,
    DEC_WAIT = 2'd3
  } yield_dec_e;
endpackage

// File: rtl/yield_sync.sv
module yield_sync #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;
endmodule

// File: rtl/yield_mask_reg.sv
module yield_mask_reg #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         priv,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask,
  output logic         err
);
  logic [W-1:0] mask_q;
  logic         err_q;
  logic         err_d;
  logic         load_en;

  always_comb begin
    load_en = wr_en && priv;
    err_d   = wr_en && !priv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (load_en) mask_q <= wdata;
      err_q <= err_d;
    end
  end

  assign mask = mask_q;
  assign err  = err_q;
endmodule

// File: rtl/yield_ctx.sv
module yield_ctx
  import yield_gate_pkg::*;
#(
  parameter int QUAL_W = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [QUAL_W:0]   opnd,
  input  logic [QUAL_W-1:0] mask,
  input  logic [QUAL_W-1:0] evt,
  output logic              blocked,
  output logic              resume,
  output logic              trap
);
  logic              blk_q, blk_d;
  logic              res_q, res_d;
  logic              trp_q, trp_d;
  logic [QUAL_W-1:0] sel_q;
  logic [QUAL_W-1:0] sel;
  logic              sel_en;
  yield_dec_e        dec;

  assign sel = opnd[QUAL_W-1:0];

  always_comb begin
    if (!req || blk_q)                   dec = DEC_NONE;
    else if (opnd[QUAL_W] || sel == '0)  dec = DEC_GO;
    else if (|(sel & ~mask))             dec = DEC_TRAP;
    else if (|(sel & evt))               dec = DEC_GO;
    else                                 dec = DEC_WAIT;
  end

  always_comb begin
    blk_d  = blk_q;
    res_d  = 1'b0;
    trp_d  = 1'b0;
    sel_en = 1'b0;
    if (blk_q) begin
      if (|(sel_q & evt)) begin
        blk_d = 1'b0;
        res_d = 1'b1;
      end
    end else begin
      case (dec)
        DEC_GO:   res_d = 1'b1;
        DEC_TRAP: trp_d = 1'b1;
        DEC_WAIT: begin
          blk_d  = 1'b1;
          sel_en = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= 1'b0;
      res_q <= 1'b0;
      trp_q <= 1'b0;
      sel_q <= '0;
    end else begin
      blk_q <= blk_d;
      res_q <= res_d;
      trp_q <= trp_d;
      if (sel_en) sel_q <= sel;
    end
  end

  assign blocked = blk_q;
  assign resume  = res_q;
  assign trap    = trp_q;
endmodule

// File: rtl/yield_gate.sv
module yield_gate #(
  parameter int NUM_CTX = 4,
  parameter int QUAL_W  = 31,
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [QUAL_W-1:0]  evt_in,
  input  logic               req_vld,
  input  logic [CTX_W-1:0]   req_ctx,
  input  logic [QUAL_W:0]    req_opnd,
  input  logic               cfg_wr_en,
  input  logic               cfg_priv,
  input  logic [QUAL_W-1:0]  cfg_wdata,
  output logic [QUAL_W-1:0]  perm_mask,
  output logic               cfg_err,
  output logic [NUM_CTX-1:0] ctx_blocked,
  output logic [NUM_CTX-1:0] ctx_resume,
  output logic [NUM_CTX-1:0] ctx_trap
);
  logic [QUAL_W-1:0] evt_sync;

  yield_sync #(.W(QUAL_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (evt_in),
    .d_sync  (evt_sync)
  );

  yield_mask_reg #(.W(QUAL_W)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr_en),
    .priv  (cfg_priv),
    .wdata (cfg_wdata),
    .mask  (perm_mask),
    .err   (cfg_err)
  );

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    logic req_here;
    assign req_here = req_vld && (req_ctx == CTX_W'(c));

    yield_ctx #(.QUAL_W(QUAL_W)) u_ctx (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req_here),
      .opnd    (req_opnd),
      .mask    (perm_mask),
      .evt     (evt_sync),
      .blocked (ctx_blocked[c]),
      .resume  (ctx_resume[c]),
      .trap    (ctx_trap[c])
    );
  end
endmodule

// File: rtl/yield_gate_chk.sv
module yield_gate_chk #(
  parameter int NUM_CTX = 4,
  parameter int QUAL_W  = 31,
  parameter int CTX_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wr_en,
  input logic               cfg_priv,
  input logic [QUAL_W-1:0]  cfg_wdata,
  input logic [QUAL_W-1:0]  perm_mask,
  input logic               cfg_err,
  input logic [NUM_CTX-1:0] ctx_blocked,
  input logic [NUM_CTX-1:0] ctx_resume,
  input logic [NUM_CTX-1:0] ctx_trap
);
  assert_trap_excl_resume_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_trap & ctx_resume) == '0);

  assert_trap_never_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_trap & ctx_blocked) == '0);

  assert_priv_write_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_priv) |=> (perm_mask == $past(cfg_wdata)));

  assert_unpriv_mask_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && !cfg_priv) |=> $stable(perm_mask));

  assert_unpriv_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && !cfg_priv) |=> cfg_err);

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_chk
    assert_wake_pulses_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctx_blocked[c]) |-> ctx_resume[c]);

    assert_block_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctx_blocked[c]) |-> (!ctx_resume[c] && !ctx_trap[c]));
  end
endmodule

bind yield_gate yield_gate_chk #(
  .NUM_CTX (NUM_CTX),
  .QUAL_W  (QUAL_W),
  .CTX_W   (CTX_W)
) u_yield_gate_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_priv    (cfg_priv),
  .cfg_wdata   (cfg_wdata),
  .perm_mask   (perm_mask),
  .cfg_err     (cfg_err),
  .ctx_blocked (ctx_blocked),
  .ctx_resume  (ctx_resume),
  .ctx_trap    (ctx_trap)
);

// File: tb/test_yield_gate.sv
module test_yield_gate;
  localparam int NC = 4;
  localparam int QW = 31;

  logic          clk;
  logic          rst_n;
  logic [QW-1:0] evt_in;
  logic          req_vld;
  logic [1:0]    req_ctx;
  logic [QW:0]   req_opnd;
  logic          cfg_wr_en, cfg_priv;
  logic [QW-1:0] cfg_wdata;
  logic [QW-1:0] perm_mask;
  logic          cfg_err;
  logic [NC-1:0] ctx_blocked, ctx_resume, ctx_trap;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  yield_gate #(.NUM_CTX(NC), .QUAL_W(QW)) i_yield_gate (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .req_vld(req_vld),
    .req_ctx(req_ctx), .req_opnd(req_opnd), .cfg_wr_en(cfg_wr_en),
    .cfg_priv(cfg_priv), .cfg_wdata(cfg_wdata), .perm_mask(perm_mask),
    .cfg_err(cfg_err), .ctx_blocked(ctx_blocked), .ctx_resume(ctx_resume),
    .ctx_trap(ctx_trap)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [QW-1:0] m_mask, m_evt_a, m_evt_b;
  logic [QW-1:0] m_sel [NC];
  logic [NC-1:0] m_blk, m_res, m_trp;
  logic          m_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = '0; m_evt_a = '0; m_evt_b = '0; m_blk = '0; m_res = '0;
      m_trp = '0; m_err = 1'b0;
      for (int c = 0; c < NC; c++) m_sel[c] = '0;
    end else begin
      for (int c = 0; c < NC; c++) begin
        m_res[c] = 1'b0;
        m_trp[c] = 1'b0;
        if (m_blk[c]) begin
          if ((m_sel[c] & m_evt_b) != 0) begin m_blk[c] = 1'b0; m_res[c] = 1'b1; end
        end else if (req_vld && int'(req_ctx) == c) begin
          if (req_opnd[QW] || req_opnd == 0) m_res[c] = 1'b1;
          else if ((req_opnd[QW-1:0] & ~m_mask) != 0) m_trp[c] = 1'b1;
          else if ((req_opnd[QW-1:0] & m_evt_b) != 0) m_res[c] = 1'b1;
          else begin m_blk[c] = 1'b1; m_sel[c] = req_opnd[QW-1:0]; end
        end
      end
      m_err = cfg_wr_en && !cfg_priv;
      if (cfg_wr_en && cfg_priv) m_mask = cfg_wdata;
      m_evt_b = m_evt_a;
      m_evt_a = evt_in;
    end
    #1;
    if (rst_n) begin
      check("R2 blocked vs model", 64'(ctx_blocked), 64'(m_blk));
      check("R3 resume vs model", 64'(ctx_resume), 64'(m_res));
      check("R5 trap vs model", 64'(ctx_trap), 64'(m_trp));
      check("R8 cfg_err vs model", 64'(cfg_err), 64'(m_err));
      check("R7 mask vs model", 64'(perm_mask), 64'(m_mask));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic issue(input int ctx, input logic [QW:0] op);
    @(negedge clk);
    req_vld = 1'b1; req_ctx = 2'(ctx); req_opnd = op;
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  task automatic wr(input logic pr, input logic [QW-1:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_priv = pr; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; evt_in = '0; req_vld = 1'b0; req_ctx = '0; req_opnd = '0;
    cfg_wr_en = 1'b0; cfg_priv = 1'b0; cfg_wdata = '0;
    idle(3);
    check("R10 reset outputs", 64'({ctx_blocked, ctx_resume, ctx_trap, cfg_err}), 64'd0);
    check("R10 reset mask", 64'(perm_mask), 64'd0);
    rst_n = 1'b1;

    // R8: unprivileged write ignored, error pulse
    wr(1'b0, 31'h0000_00FF);
    check("R8 err pulse", 64'(cfg_err), 64'd1);
    check("R8 mask kept", 64'(perm_mask), 64'd0);
    idle(1);
    check("R8 err one cycle", 64'(cfg_err), 64'd0);

    // R7: reset mask traps any positive request
    issue(0, 32'h0000_0001);
    check("R7 zero mask traps", 64'(ctx_trap), 64'h1);

    wr(1'b1, 31'h4000_00FF);
    check("R7 mask loaded", 64'(perm_mask), 64'h4000_00FF);

    // R5: forbidden line active still traps
    evt_in = 31'h0000_0100;
    idle(3);
    issue(0, 32'h0000_0101);
    check("R5 trap has priority", 64'({ctx_trap[0], ctx_resume[0], ctx_blocked[0]}), 64'b100);
    evt_in = '0;
    idle(3);

    // R2: permitted, nothing active -> block
    issue(1, 32'h0000_0003);
    check("R2 ctx1 blocked", 64'({ctx_blocked[1], ctx_resume[1], ctx_trap[1]}), 64'b100);

    // R9: re-request ignored, other contexts served
    issue(1, 32'h0000_0000);
    check("R9 blocked ctx ignores request", 64'({ctx_blocked[1], ctx_resume[1]}), 64'b10);
    issue(2, 32'h0000_0000);
    check("R9 other ctx served", 64'({ctx_resume[2], ctx_blocked[1]}), 64'b11);

    // R3: selected line already active -> immediate resume
    evt_in = 31'h0000_0004;
    idle(3);
    issue(2, 32'h0000_0004);
    check("R3 immediate resume", 64'({ctx_resume[2], ctx_blocked[2]}), 64'b10);
    evt_in = '0;
    idle(3);

    // R6: non-positive operands proceed, even with bits outside mask
    issue(0, 32'h8000_0100);
    check("R6 negative proceeds", 64'({ctx_resume[0], ctx_trap[0], ctx_blocked[0]}), 64'b100);
    issue(3, 32'h0000_0000);
    check("R6 zero proceeds", 64'({ctx_resume[3], ctx_trap[3], ctx_blocked[3]}), 64'b100);

    // R1 + R4: bit 30 selection and wake timing
    issue(3, 32'h4000_0000);
    check("R1 bit30 blocks", 64'(ctx_blocked[3]), 64'd1);
    @(negedge clk);
    evt_in = 31'h4000_0000;
    idle(2);
    check("R4 no early wake", 64'({ctx_blocked[3], ctx_resume[3]}), 64'b10);
    idle(1);
    check("R4 wake on third edge", 64'({ctx_blocked[3], ctx_resume[3]}), 64'b01);
    idle(1);
    check("R4 resume one cycle", 64'(ctx_resume[3]), 64'd0);
    check("R9 ctx1 still blocked", 64'(ctx_blocked[1]), 64'd1);

    // R4: wake ctx1 through bit 0
    evt_in = 31'h0000_0001;
    idle(3);
    check("R4 ctx1 wakes", 64'({ctx_blocked[1], ctx_resume[1]}), 64'b01);
    evt_in = '0;
    idle(4);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule